// File: doc/BRIEF.md
# Phase Condition Flag Register

This block tracks one phase of a polyphase energy meter and holds a byte of sticky condition flags for it. Upstream logic supplies the RMS voltage and RMS current of the phase, the signs of real and reactive power, a strobe for each voltage zero crossing, and a strobe that marks the end of each DSP cycle. The block also takes three programmable thresholds. It decides at every DSP-cycle end whether any condition has occurred. Once a flag is set, it stays set until the host clears it by writing ones to the flag's bit position.

Each flag has its own mask bit. The registered interrupt-forward vector carries a flag on to a global interrupt collector only while the flag's mask bit is set. Sign history for the two direction-change checks starts out unknown after reset. The first DSP-cycle end after reset only loads that history.

Top module: `phase_cond_flags`

## Requirements
- R1: `flags` has this layout: bit 0 overcurrent, bit 1 overvoltage, bit 2 undervoltage, bit 3 no zero crossing, bit 4 real-power direction change, bit 5 reactive-power direction change. Bits 7:6 always read 0.
- R2: At a cycle end, overcurrent sets when `irms` is strictly greater than `oc_lvl`, with both values unsigned.
- R3: At a cycle end, overvoltage sets when `vrms` is strictly greater than `ov_lvl`, with both values unsigned.
- R4: At a cycle end, undervoltage sets when `vrms` is strictly less than `uv_lvl`, with both values unsigned.
- R5: At a cycle end, no-zero-crossing sets when `zc_stb` was low in every clock since the previous cycle end (or since reset), up to and including the current clock. The watch restarts after each cycle end.
- R6: At a cycle end, the real direction-change flag sets when `p_real_neg` differs from its value at the previous cycle end.
- R7: At a cycle end, the reactive direction-change flag sets when `p_react_neg` differs from its value at the previous cycle end.
- R8: The first cycle end after reset only loads the sign history. It never sets either direction-change flag.
- R9: Flags are sticky. When `clr_we` is high, each bit of `clr_data` that is 1 clears the flag in the same position. Bits of `clr_data` that are 0 leave their flags unchanged.
- R10: When a set condition and a clear for the same flag arrive in one clock, the flag ends up set.
- R11: After each clock edge, `irq_fwd[i]` equals the new value of `flags[i]` ANDed with `mask[i]` as sampled at that edge.
- R12: No flag sets in a clock where `cyc_end` is low.
- R13: After reset, `flags` and `irq_fwd` both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_end | input | 1 | DSP-cycle end strobe |
| zc_stb | input | 1 | Voltage zero-crossing strobe |
| vrms | input | W | RMS voltage |
| irms | input | W | RMS current |
| p_real_neg | input | 1 | Real power sign (1 = toward line) |
| p_react_neg | input | 1 | Reactive power sign (1 = capacitive) |
| uv_lvl | input | W | Undervoltage threshold |
| ov_lvl | input | W | Overvoltage threshold |
| oc_lvl | input | W | Overcurrent threshold |
| mask | input | 6 | Per-flag forward enable |
| clr_we | input | 1 | Host clear strobe |
| clr_data | input | 6 | Write-one-to-clear bits |
| flags | output | 8 | Sticky condition flags |
| irq_fwd | output | 6 | Masked flags toward the global collector |

## Verification
The sign history and the zero-crossing watch are hidden state, and neither is visible directly at the ports. A wrong sign history shows up at the very next cycle end as a spurious or missing direction-change bit. A wrong zero-crossing watch shows up in bit 3 at the cycle end that closes the window. A fault in the sticky register appears on the clock after a clear or a cycle end. The bench compares `flags` and `irq_fwd` against a reference model after every clock, so any such divergence is reported in the clock where it first shows.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  localparam int NFLAG     = 6;
  localparam int FLAG_BYTE = 8;
  localparam int B_OC      = 0;
  localparam int B_OV      = 1;
  localparam int B_UV      = 2;
  localparam int B_NOZX    = 3;
  localparam int B_DREAL   = 4;
  localparam int B_DREACT  = 5;
  localparam int NSIGN     = 2;
endpackage

// File: rtl/pcf_level_cmp.sv
module pcf_level_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] vrms,
  input  logic [W-1:0] irms,
  input  logic [W-1:0] uv_lvl,
  input  logic [W-1:0] ov_lvl,
  input  logic [W-1:0] oc_lvl,
  output logic         uv_hit,
  output logic         ov_hit,
  output logic         oc_hit
);
  always_comb begin
    uv_hit = vrms < uv_lvl;
    ov_hit = vrms > ov_lvl;
    oc_hit = irms > oc_lvl;
  end

  // R3 R4: with ordered thresholds both voltage conditions cannot hold together
  always_comb begin
    if (uv_lvl <= ov_lvl)
      assert_uv_ov_exclusive_R4: assert (!(uv_hit && ov_hit));
  end
endmodule

// File: rtl/pcf_zc_watch.sv
module pcf_zc_watch (
  input  logic clk,
  input  logic rst,
  input  logic cyc_end,
  input  logic zc_stb,
  output logic missing
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst)          seen_q <= 1'b0;
    else if (cyc_end) seen_q <= 1'b0;
    else              seen_q <= seen_q | zc_stb;
  end

  assign missing = cyc_end & ~(seen_q | zc_stb);

  assert_zc_remembered_R5: assert property (@(posedge clk) disable iff (rst)
    (zc_stb && !cyc_end) |=> !missing);
endmodule

// File: rtl/pcf_dir_detect.sv
module pcf_dir_detect (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  input  logic sign_in,
  output logic flip
);
  logic hist_q;
  logic valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (sample) begin
      hist_q  <= sign_in;
      valid_q <= 1'b1;
    end
  end

  assign flip = sample & valid_q & (sign_in ^ hist_q);

  assert_first_sample_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> ($past(sample) && !$past(flip)));
endmodule

// File: rtl/phase_cond_flags.sv
module phase_cond_flags
  import pcf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cyc_end,
  input  logic                 zc_stb,
  input  logic [W-1:0]         vrms,
  input  logic [W-1:0]         irms,
  input  logic                 p_real_neg,
  input  logic                 p_react_neg,
  input  logic [W-1:0]         uv_lvl,
  input  logic [W-1:0]         ov_lvl,
  input  logic [W-1:0]         oc_lvl,
  input  logic [NFLAG-1:0]     mask,
  input  logic                 clr_we,
  input  logic [NFLAG-1:0]     clr_data,
  output logic [FLAG_BYTE-1:0] flags,
  output logic [NFLAG-1:0]     irq_fwd
);
  localparam int PAD = FLAG_BYTE - NFLAG;

  logic uv_hit, ov_hit, oc_hit, nozx;
  logic [NSIGN-1:0] sgn_in, chg;
  logic [NFLAG-1:0] flag_q, irq_q, set_vec, clr_vec, flag_nx;

  pcf_level_cmp #(.W(W)) u_cmp (
    .vrms(vrms), .irms(irms), .uv_lvl(uv_lvl), .ov_lvl(ov_lvl), .oc_lvl(oc_lvl),
    .uv_hit(uv_hit), .ov_hit(ov_hit), .oc_hit(oc_hit)
  );

  pcf_zc_watch u_zc (
    .clk(clk), .rst(rst), .cyc_end(cyc_end), .zc_stb(zc_stb), .missing(nozx)
  );

  assign sgn_in = {p_react_neg, p_real_neg};

  for (genvar g = 0; g < NSIGN; g++) begin : g_dir
    pcf_dir_detect u_dir (
      .clk(clk), .rst(rst), .sample(cyc_end), .sign_in(sgn_in[g]), .flip(chg[g])
    );
  end

  always_comb begin
    set_vec = '0;
    if (cyc_end) begin
      set_vec[B_OC]     = oc_hit;
      set_vec[B_OV]     = ov_hit;
      set_vec[B_UV]     = uv_hit;
      set_vec[B_NOZX]   = nozx;
      set_vec[B_DREAL]  = chg[0];
      set_vec[B_DREACT] = chg[1];
    end
    clr_vec = clr_we ? clr_data : '0;
    flag_nx = (flag_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_q  <= '0;
    end else begin
      flag_q <= flag_nx;
      irq_q  <= flag_nx & mask;
    end
  end

  assign flags   = {{PAD{1'b0}}, flag_q};
  assign irq_fwd = irq_q;

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(flag_q) & ~$past(clr_vec)) & ~flag_q) == '0));

  assert_no_set_between_ends_R12: assert property (@(posedge clk) disable iff (rst)
    !cyc_end |=> ((flag_q & ~$past(flag_q)) == '0));

  assert_fwd_within_mask_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_fwd & ~$past(mask)) == '0));
endmodule

// File: tb/phase_cond_flags_tb.sv
module phase_cond_flags_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst;
  logic cyc_end, zc_stb, p_real_neg, p_react_neg, clr_we;
  logic [W-1:0] vrms, irms, uv_lvl, ov_lvl, oc_lvl;
  logic [5:0] mask, clr_data, irq_fwd;
  logic [7:0] flags;

  int checks = 0;
  int errors = 0;

  logic [5:0] m_flags, m_irq;
  logic m_seen, m_valid;
  logic [1:0] m_hist;

  always #10 clk = ~clk;

  phase_cond_flags #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .cyc_end(cyc_end), .zc_stb(zc_stb),
    .vrms(vrms), .irms(irms), .p_real_neg(p_real_neg), .p_react_neg(p_react_neg),
    .uv_lvl(uv_lvl), .ov_lvl(ov_lvl), .oc_lvl(oc_lvl), .mask(mask),
    .clr_we(clr_we), .clr_data(clr_data), .flags(flags), .irq_fwd(irq_fwd)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] set_bits();
    logic [5:0] s = '0;
    if (cyc_end) begin
      s[0] = irms > oc_lvl;
      s[1] = vrms > ov_lvl;
      s[2] = vrms < uv_lvl;
      s[3] = !(m_seen || zc_stb);
      s[4] = m_valid && (p_real_neg != m_hist[0]);
      s[5] = m_valid && (p_react_neg != m_hist[1]);
    end
    return s;
  endfunction

  // one clock: compute reference next state, apply edge, compare at negedge
  task automatic step();
    logic [5:0] nx;
    nx = (m_flags & ~(clr_we ? clr_data : 6'h0)) | set_bits();
    if (cyc_end) begin
      m_seen  = 1'b0;
      m_hist  = {p_react_neg, p_real_neg};
      m_valid = 1'b1;
    end else begin
      m_seen = m_seen | zc_stb;
    end
    m_flags = nx;
    m_irq   = nx & mask;
    @(posedge clk);
    @(negedge clk);
    check("R9 model flags", flags, {2'b00, m_flags});
    check("R11 model irq_fwd", {2'b00, irq_fwd}, {2'b00, m_irq});
    check("R1 reserved bits", {6'h0, flags[7:6]}, 8'h00);
  endtask

  task automatic idle();
    cyc_end = 0; zc_stb = 0; clr_we = 0; clr_data = 0;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1; idle();
    vrms = 150; irms = 0; p_real_neg = 0; p_react_neg = 0;
    uv_lvl = 100; ov_lvl = 200; oc_lvl = 300; mask = 6'h3F;
    m_flags = 0; m_irq = 0; m_seen = 0; m_valid = 0; m_hist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R13 reset flags", flags, 8'h00);
    check("R13 reset irq_fwd", {2'b00, irq_fwd}, 8'h00);

    // first cycle end: equal current, in-range voltage, zero crossing seen
    idle(); cyc_end = 1; zc_stb = 1; irms = 300; p_real_neg = 1; p_react_neg = 1;
    step();
    check("R8 first sample no direction flag", flags, 8'h00);
    check("R2 strict at equality", flags, 8'h00);

    // conditions present but no cycle end
    idle(); vrms = 250; irms = 400; p_real_neg = 0;
    step();
    check("R12 no set without cyc_end", flags, 8'h00);

    // cycle end: voltage at ov level, current above, no zc, real flip
    idle(); cyc_end = 1; vrms = 200; irms = 301;
    step();
    check("R2 R3 R5 R6 flags", flags, 8'h19);

    // clear overcurrent while it is being set again
    idle(); cyc_end = 1; zc_stb = 1; clr_we = 1; clr_data = 6'h01;
    step();
    check("R10 set wins over clear", flags, 8'h19);

    // partial clear
    idle(); clr_we = 1; clr_data = 6'h10;
    step();
    check("R9 per-bit clear", flags, 8'h09);

    idle(); clr_we = 1; clr_data = 6'h3F; irms = 0;
    step();
    check("R9 full clear", flags, 8'h00);

    // undervoltage and reactive flip, partial mask
    idle(); cyc_end = 1; zc_stb = 1; vrms = 99; p_react_neg = 0; mask = 6'h04;
    step();
    check("R4 R7 flags", flags, 8'h24);
    check("R11 masked forward", {2'b00, irq_fwd}, 8'h04);

    // overvoltage, mask off
    idle(); cyc_end = 1; zc_stb = 1; vrms = 201; mask = 6'h00;
    step();
    check("R3 overvoltage", flags, 8'h26);
    check("R11 mask off", {2'b00, irq_fwd}, 8'h00);

    // zc strobe earlier in cycle prevents nozx
    idle(); clr_we = 1; clr_data = 6'h3F; zc_stb = 1; vrms = 150; mask = 6'h3F;
    step();
    idle();
    step();
    idle(); cyc_end = 1;
    step();
    check("R5 earlier strobe counts", flags, 8'h00);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      cyc_end     = ($urandom % 4) == 0;
      zc_stb      = ($urandom % 6) == 0;
      vrms        = W'($urandom % 400);
      irms        = W'($urandom % 400);
      uv_lvl      = W'(80 + $urandom % 60);
      ov_lvl      = W'(220 + $urandom % 60);
      oc_lvl      = W'(200 + $urandom % 150);
      p_real_neg  = ($urandom % 5) == 0 ? ~p_real_neg : p_real_neg;
      p_react_neg = ($urandom % 5) == 0 ? ~p_react_neg : p_react_neg;
      mask        = 6'($urandom);
      clr_we      = ($urandom % 3) == 0;
      clr_data    = 6'($urandom);
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule